// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an 8-bit general-purpose I/O port on a simple memory-mapped register bus. The bus carries an address, a write enable, write data, and a combinational read data return. The port has two registers: an output latch and a direction register. A third, read-only address returns the pin levels after they pass through a synchronizer. Each pin has three controls:

- an output value;
- an output enable;
- a pull-up enable.

For an input pin, the latch bit also acts as the pull-up enable. Besides full-byte writes, the bus has single-bit set and clear strobes with a bit index. These let software change one pin without touching the other bits of the same register.

The pin controls come from one of three operating modes, chosen combinationally:

- **PM_TRISTATE**: entered at once whenever reset is asserted, with or without a clock. It overrides every other condition. All output enables and pull-ups are off.
- **PM_GPIO**: entered when reset is released and the external-memory enable is low. The registers drive the pins.
- **PM_ALT**: entered when reset is released and the external-memory enable is high. An external multiplexed address/data bus takes the pins. It supplies the output values and a single port-wide drive enable, the direction register is ignored, and all pull-ups are on. Clearing the external-memory enable moves the port straight back to PM_GPIO.

Register updates are decoded into one of four operations, with a byte write outranking the other three:

- **OP_BYTE**: a full-byte write.
- **OP_SET**: a bit set.
- **OP_CLR**: a bit clear.
- **OP_HOLD**: no change.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset both the latch (address 0x1B) and the direction register (address 0x1A) read back as zero.
- R2: A byte write (`bus_we` high) to 0x1B or 0x1A stores `bus_wdata`, and a read of the same address after that clock edge returns it.
- R3: With `bus_we` low, `bus_bset` sets bit `bus_bidx` of the addressed register and `bus_bclr` clears it, and every other bit keeps its value. Set wins over clear, and a byte write wins over both.
- R4: Reading 0x19 returns `pad_in` through a two-stage synchronizer: a change is not visible after one clock edge and is visible after the second.
- R5: In PM_GPIO, a pin whose direction bit is 1 has `pad_oe` high, `pad_out` equal to its latch bit, and `pad_pu` low.
- R6: In PM_GPIO, a pin whose direction bit is 0 has `pad_oe` low and `pad_pu` equal to its latch bit. `pad_out` always carries the latch value in this mode.
- R7: In PM_ALT (`ext_mem_en` high), every bit of `pad_oe` equals `alt_oe`, `pad_out` equals `alt_out`, and `pad_pu` is all ones, whatever the direction register holds.
- R8: While `rst_n` is low, `pad_oe`, `pad_pu` and `pad_out` are all zero at once, without waiting for a clock edge.
- R9: Reads of any address other than 0x19, 0x1A and 0x1B return zero. Writes and bit operations to 0x19 or to unmapped addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| bus_addr | input | 6 | Register address |
| bus_we | input | 1 | Full-byte write strobe |
| bus_wdata | input | 8 | Write data |
| bus_bset | input | 1 | Single-bit set strobe |
| bus_bclr | input | 1 | Single-bit clear strobe |
| bus_bidx | input | 3 | Bit index for set/clear |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_mem_en | input | 1 | Hands the pins to the external address/data bus |
| alt_out | input | 8 | External bus output values |
| alt_oe | input | 1 | External bus drive enable for the whole port |
| pad_in | input | 8 | Pin levels, asynchronous |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |
| pad_pu | output | 8 | Pin pull-up enables |

## Verification
The assertions assume that the strobes, address, bit index and write data hold steady around each rising clock edge. They also assume that `bus_bidx` lies below the port width, and that reset is asserted long enough for the synchronizer to clear. The bench changes inputs only at falling edges and draws the bit index from the valid range. It applies and releases reset away from the rising edge, so the asynchronous tri-state behaviour can be seen without racing a register update. Addresses are drawn randomly from a window that includes the unmapped neighbours of the three register addresses.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_BYTE,
        OP_SET,
        OP_CLR
    } reg_op_e;

    typedef enum logic [1:0] {
        PM_TRISTATE,
        PM_GPIO,
        PM_ALT
    } pin_mode_e;

    // Byte write outranks set, set outranks clear.
    function automatic reg_op_e decode_op(input logic we, input logic bset, input logic bclr);
        if (we)        return OP_BYTE;
        else if (bset) return OP_SET;
        else if (bclr) return OP_CLR;
        else           return OP_HOLD;
    endfunction

endpackage

// File: rtl/gpio_port_reg.sv
module gpio_port_reg
    import gpio_port_pkg::*;
#(
    parameter int                WIDTH   = 8,
    parameter int                ADDR_W  = 6,
    parameter logic [ADDR_W-1:0] MY_ADDR = '0,
    localparam int               IDX_W   = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_bset,
    input  logic              bus_bclr,
    input  logic [IDX_W-1:0]  bus_bidx,
    output logic [WIDTH-1:0]  q
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    reg_op_e          op;
    logic [WIDTH-1:0] bit_mask;
    logic [WIDTH-1:0] nxt;

    assign bit_mask = ONE << bus_bidx;

    always_comb begin
        if (bus_addr == MY_ADDR) op = decode_op(bus_we, bus_bset, bus_bclr);
        else                     op = OP_HOLD;
    end

    always_comb begin
        unique case (op)
            OP_HOLD: nxt = q;
            OP_BYTE: nxt = bus_wdata;
            OP_SET:  nxt = q | bit_mask;
            OP_CLR:  nxt = q & ~bit_mask;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_padmux.sv
module gpio_port_padmux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             rst_n,
    input  logic             ext_mem_en,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] alt_out,
    input  logic             alt_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);

    pin_mode_e mode;

    // Reset outranks everything and needs no clock.
    always_comb begin
        if (!rst_n)          mode = PM_TRISTATE;
        else if (ext_mem_en) mode = PM_ALT;
        else                 mode = PM_GPIO;
    end

    always_comb begin
        unique case (mode)
            PM_TRISTATE: begin
                pad_out = '0;
                pad_oe  = '0;
                pad_pu  = '0;
            end
            PM_GPIO: begin
                pad_out = latch_q;
                pad_oe  = dir_q;
                pad_pu  = latch_q & ~dir_q;
            end
            PM_ALT: begin
                pad_out = alt_out;
                pad_oe  = {WIDTH{alt_oe}};
                pad_pu  = '1;
            end
            default: begin
                pad_out = '0;
                pad_oe  = '0;
                pad_pu  = '0;
            end
        endcase
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
    parameter int                WIDTH       = 8,
    parameter int                ADDR_W      = 6,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] PIN_ADDR    = 6'h19,
    parameter logic [ADDR_W-1:0] DIR_ADDR    = 6'h1A,
    parameter logic [ADDR_W-1:0] LATCH_ADDR  = 6'h1B,
    localparam int               IDX_W       = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_bset,
    input  logic              bus_bclr,
    input  logic [IDX_W-1:0]  bus_bidx,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              ext_mem_en,
    input  logic [WIDTH-1:0]  alt_out,
    input  logic              alt_oe,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu
);

    localparam int NREG = 2;

    logic [NREG-1:0][WIDTH-1:0] reg_q;
    logic [WIDTH-1:0]           latch_q;
    logic [WIDTH-1:0]           dir_q;
    logic [WIDTH-1:0]           pin_sync;

    // Index 0 is the output latch, index 1 is the direction register.
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        gpio_port_reg #(
            .WIDTH   (WIDTH),
            .ADDR_W  (ADDR_W),
            .MY_ADDR ((r == 0) ? LATCH_ADDR : DIR_ADDR)
        ) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_addr  (bus_addr),
            .bus_we    (bus_we),
            .bus_wdata (bus_wdata),
            .bus_bset  (bus_bset),
            .bus_bclr  (bus_bclr),
            .bus_bidx  (bus_bidx),
            .q         (reg_q[r])
        );
    end

    assign latch_q = reg_q[0];
    assign dir_q   = reg_q[1];

    gpio_port_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (pin_sync)
    );

    gpio_port_padmux #(
        .WIDTH (WIDTH)
    ) u_padmux (
        .rst_n      (rst_n),
        .ext_mem_en (ext_mem_en),
        .latch_q    (latch_q),
        .dir_q      (dir_q),
        .alt_out    (alt_out),
        .alt_oe     (alt_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pad_pu     (pad_pu)
    );

    always_comb begin
        if (bus_addr == LATCH_ADDR)    bus_rdata = latch_q;
        else if (bus_addr == DIR_ADDR) bus_rdata = dir_q;
        else if (bus_addr == PIN_ADDR) bus_rdata = pin_sync;
        else                           bus_rdata = '0;
    end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int                WIDTH      = 8,
    parameter int                ADDR_W     = 6,
    parameter logic [ADDR_W-1:0] PIN_ADDR   = 6'h19,
    parameter logic [ADDR_W-1:0] DIR_ADDR   = 6'h1A,
    parameter logic [ADDR_W-1:0] LATCH_ADDR = 6'h1B,
    localparam int               IDX_W      = $clog2(WIDTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic              bus_bset,
    input logic              bus_bclr,
    input logic [IDX_W-1:0]  bus_bidx,
    input logic              ext_mem_en,
    input logic [WIDTH-1:0]  alt_out,
    input logic              alt_oe,
    input logic [WIDTH-1:0]  pad_in,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_pu,
    input logic [WIDTH-1:0]  latch_q,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  pin_sync
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [1:0] edges_since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      edges_since_rst <= '0;
        else if (edges_since_rst != 2'd3) edges_since_rst <= edges_since_rst + 2'd1;
    end

    // R8
    always_comb begin
        if (!rst_n) begin
            reset_tristate_chk: assert (pad_oe == '0 && pad_pu == '0 && pad_out == '0);
        end
    end

    // R7
    always_comb begin
        if (rst_n && ext_mem_en) begin
            alt_override_chk: assert (pad_oe == {WIDTH{alt_oe}} && pad_out == alt_out && pad_pu == '1);
        end
    end

    // R2
    latch_byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == LATCH_ADDR) |=> latch_q == $past(bus_wdata));

    // R3
    dir_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && bus_bset && bus_addr == DIR_ADDR)
        |=> dir_q == ($past(dir_q) | (ONE << $past(bus_bidx))));

    // R3
    latch_bit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && !bus_bset && bus_bclr && bus_addr == LATCH_ADDR)
        |=> latch_q == ($past(latch_q) & ~(ONE << $past(bus_bidx))));

    // R4
    pin_sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_since_rst >= 2'd2) |-> pin_sync == $past(pad_in, 2));

    // R9
    pin_addr_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == PIN_ADDR) |=> ($stable(latch_q) && $stable(dir_q)));

    // R6
    no_pullup_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mem_en |-> (pad_pu & pad_oe) == '0);

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .WIDTH      (WIDTH),
    .ADDR_W     (ADDR_W),
    .PIN_ADDR   (PIN_ADDR),
    .DIR_ADDR   (DIR_ADDR),
    .LATCH_ADDR (LATCH_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_bset   (bus_bset),
    .bus_bclr   (bus_bclr),
    .bus_bidx   (bus_bidx),
    .ext_mem_en (ext_mem_en),
    .alt_out    (alt_out),
    .alt_oe     (alt_oe),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_pu     (pad_pu),
    .latch_q    (latch_q),
    .dir_q      (dir_q),
    .pin_sync   (pin_sync)
);

// File: tb/gpio_port_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctrl_bench;

    localparam int W = 8;
    localparam logic [5:0] A_PIN = 6'h19, A_DIR = 6'h1A, A_LAT = 6'h1B;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic         bus_we = 1'b0, bus_bset = 1'b0, bus_bclr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [2:0]   bus_bidx = '0;
    logic [W-1:0] bus_rdata;
    logic         ext_mem_en = 1'b0, alt_oe = 1'b0;
    logic [W-1:0] alt_out = '0, pad_in = '0;
    logic [W-1:0] pad_out, pad_oe, pad_pu;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model of the architectural state.
    logic [W-1:0] m_lat = '0, m_dir = '0, m_s1 = '0, m_s2 = '0;

    always #2.5 clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_bset(bus_bset), .bus_bclr(bus_bclr),
        .bus_bidx(bus_bidx), .bus_rdata(bus_rdata), .ext_mem_en(ext_mem_en),
        .alt_out(alt_out), .alt_oe(alt_oe), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] next_reg(input logic [W-1:0] q, input logic [5:0] my_addr);
        logic [W-1:0] m;
        m = W'(1) << bus_bidx;
        if (bus_addr != my_addr) return q;
        if (bus_we)              return bus_wdata;
        if (bus_bset)            return q | m;
        if (bus_bclr)            return q & ~m;
        return q;
    endfunction

    function automatic logic [W-1:0] exp_rdata(input logic [5:0] a);
        if (a == A_LAT) return m_lat;
        if (a == A_DIR) return m_dir;
        if (a == A_PIN) return m_s2;
        return '0;
    endfunction

    // One rising edge with the current inputs, model updated, then sample at the falling edge.
    task automatic step();
        @(posedge clk);
        m_lat = next_reg(m_lat, A_LAT);
        m_dir = next_reg(m_dir, A_DIR);
        m_s2  = m_s1;
        m_s1  = pad_in;
        @(negedge clk);
        bus_we = 0; bus_bset = 0; bus_bclr = 0;
    endtask

    task automatic check_pads(input string tag);
        if (ext_mem_en) begin
            chk(pad_oe == {W{alt_oe}}, {tag, " R7 oe"}, pad_oe, {W{alt_oe}});
            chk(pad_out == alt_out,    {tag, " R7 out"}, pad_out, alt_out);
            chk(pad_pu == '1,          {tag, " R7 pu"}, pad_pu, '1);
        end else begin
            chk(pad_oe == m_dir,            {tag, " R5 oe"}, pad_oe, m_dir);
            chk(pad_out == m_lat,           {tag, " R5 out"}, pad_out, m_lat);
            chk(pad_pu == (m_lat & ~m_dir), {tag, " R6 pu"}, pad_pu, m_lat & ~m_dir);
        end
    endtask

    task automatic read_chk(input logic [5:0] a, input string tag);
        bus_addr = a;
        #0.5;
        chk(bus_rdata == exp_rdata(a), tag, bus_rdata, exp_rdata(a));
    endtask

    task automatic wr(input logic [5:0] a, input logic [W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        step();
    endtask

    task automatic bitop(input logic [5:0] a, input logic s, input logic c, input logic [2:0] i);
        bus_addr = a; bus_bset = s; bus_bclr = c; bus_bidx = i;
        step();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        #1;
        // R8: reset tri-states pads with no clock edge needed.
        chk(pad_oe == '0 && pad_pu == '0, "R8 reset pads", pad_oe | pad_pu, '0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        read_chk(A_LAT, "R1 latch reset");
        read_chk(A_DIR, "R1 dir reset");

        // R2 byte writes
        wr(A_LAT, 8'hA5); read_chk(A_LAT, "R2 latch write");
        wr(A_DIR, 8'h3C); read_chk(A_DIR, "R2 dir write");
        check_pads("directed");

        // R3 set/clear touch only one bit, with priorities
        bitop(A_DIR, 1, 0, 3'd7); read_chk(A_DIR, "R3 set bit 7");
        bitop(A_LAT, 0, 1, 3'd0); read_chk(A_LAT, "R3 clear bit 0");
        bitop(A_LAT, 1, 1, 3'd1); read_chk(A_LAT, "R3 set beats clear");
        bus_we = 1; bus_wdata = 8'h0F; bitop(A_LAT, 1, 1, 3'd7);
        read_chk(A_LAT, "R3 byte write beats bit ops");

        // R9 pin address and unmapped writes ignored, unmapped reads zero
        wr(A_PIN, 8'hFF); read_chk(A_LAT, "R9 pin write latch"); read_chk(A_DIR, "R9 pin write dir");
        wr(6'h1C, 8'hFF); read_chk(A_LAT, "R9 unmapped write latch");
        bitop(6'h18, 1, 0, 3'd6); read_chk(A_DIR, "R9 unmapped bitop dir");
        read_chk(6'h18, "R9 unmapped read 0x18");
        read_chk(6'h00, "R9 unmapped read 0x00");

        // R4 two-stage synchronizer
        pad_in = 8'h5A; step(); read_chk(A_PIN, "R4 one edge");
        chk(bus_rdata != 8'h5A, "R4 not yet visible", bus_rdata, 8'h00);
        step(); read_chk(A_PIN, "R4 two edges");
        chk(bus_rdata == 8'h5A, "R4 visible", bus_rdata, 8'h5A);

        // R7 alternate override with a conflicting direction register
        ext_mem_en = 1; alt_out = 8'hC3; alt_oe = 0; #0.5; check_pads("R7 alt in");
        alt_oe = 1; #0.5; check_pads("R7 alt out");
        ext_mem_en = 0; #0.5; check_pads("R7 back to gpio");

        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            bus_addr  = 6'h18 + 6'($urandom_range(0, 4));
            bus_wdata = 8'($urandom);
            bus_bidx  = 3'($urandom);
            bus_we    = ($urandom_range(0, 3) == 0);
            bus_bset  = $urandom_range(0, 1);
            bus_bclr  = $urandom_range(0, 1);
            pad_in    = 8'($urandom);
            ext_mem_en = ($urandom_range(0, 3) == 0);
            alt_out   = 8'($urandom);
            alt_oe    = $urandom_range(0, 1);
            step();
            check_pads("random R5 R6 R7");
            read_chk(6'h18 + 6'($urandom_range(0, 4)), "random R2 R3 R4 R9 read");
        end

        // R8 asynchronous reset mid-run, away from the rising edge
        ext_mem_en = 1; alt_oe = 1;
        #1 rst_n = 0; #0.5;
        chk(pad_oe == '0 && pad_pu == '0 && pad_out == '0, "R8 async reset", pad_oe | pad_pu | pad_out, '0);
        m_lat = '0; m_dir = '0; m_s1 = '0; m_s2 = '0;
        ext_mem_en = 0;
        @(negedge clk); rst_n = 1; #0.5;
        read_chk(A_LAT, "R1 latch after reset");
        read_chk(A_DIR, "R1 dir after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule